// File: doc/BRIEF.md
# Banked Data Address Generator

This block turns each data access of a small 8-bit core into an extended data-memory address. It keeps four 8-bit registers: two general RAM pointers (P and Q), a stack pointer, and a bank register. An access names its source: a direct address taken from the instruction, pointer P, pointer Q, or the stack. The block forms an 8-bit base address from that source and then extends it. A base address below 0x80 is banked: its low seven bits are placed after the bank register value, so the lower half of the space reaches 256 banks of 128 bytes. A base address of 0x80 or above passes through with a zero bank field, so the upper half is common to every bank.

Pointer P or Q can be incremented or decremented after the access, wrapping modulo 256. The stack grows downward. A push uses the current stack pointer and then decrements it. A pop increments the pointer first and uses the new value. All four registers occupy a window of four data locations in the upper half, given by a parameter. A write access that lands in that window loads the register instead of writing RAM, and a read access returns the register value on the read-data port.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, P = 0x00, Q = 0x00, bank = 0x00 and the stack pointer = 0x6F. These values are read back through mapped reads.
- R2: When the base address has bit 7 clear, extAddr = {bank, 1'b0, base[6:0]}.
- R3: When the base address has bit 7 set, extAddr = {8'h00, base}.
- R4: accSrc encoding: 0 = direct (base = accDirAddr), 1 = pointer P, 2 = pointer Q, 3 = stack. For the direct source, accOp has no effect.
- R5: accOp encoding for P and Q: 0 = hold, 1 = post-increment, 2 = post-decrement, 3 = hold. The access uses the old value, and the update wraps modulo 256 (0xFF+1 = 0x00, 0x00-1 = 0xFF).
- R6: For the stack source, accOp 2 is a push: the address is SP, then SP becomes SP-1. accOp 1 is a pop: the address is SP+1, and SP becomes SP+1. accOp 0 or 3 uses SP and leaves it unchanged.
- R7: A write access whose base equals MAP_BASE+k loads wrData into register k (0 = P, 1 = Q, 2 = stack pointer, 3 = bank). During such an access memWr stays low and regHit is high.
- R8: A read access inside the mapped window drives regHit high, memRd low, and rdData with register k. A read access outside the window drives memRd high and regHit low.
- R9: If an access loads a register through the mapped window and the same access also adjusts that register, the loaded value wins.
- R10: With accValid low, no register changes and memRd, memWr and regHit stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | An access takes place this cycle |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accSrc | input | 2 | Address source (encoding in R4) |
| accOp | input | 2 | Pointer or stack adjustment (encoding in R5, R6) |
| accDirAddr | input | 8 | Direct base address |
| wrData | input | 8 | Write data, used for register loads |
| extAddr | output | 16 | Extended data-memory address |
| memRd | output | 1 | RAM read strobe |
| memWr | output | 1 | RAM write strobe |
| regHit | output | 1 | The access targets a mapped register |
| rdData | output | 8 | Mapped register read value |

## Verification
A wrong pointer or bank value shows up in extAddr on the next access that uses that register, which is usually the next cycle. A wrong stack pointer can stay hidden until the next push or pop, and a wrong bank value stays hidden while only upper-half addresses are used. The bench therefore compares every output against a behavioural model on every cycle, and it mixes lower-half and upper-half accesses so that a register error cannot stay hidden for long. Wrap points, push/pop pairs and the load-versus-adjust collision are all driven directly.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int NUM_MAPPED = 4;
  localparam int IDX_W      = $clog2(NUM_MAPPED);

  // Mapped register order: this order sets the window offsets.
  localparam int IDX_P    = 0;
  localparam int IDX_Q    = 1;
  localparam int IDX_SP   = 2;
  localparam int IDX_BANK = 3;

  typedef enum logic [1:0] {
    SRC_DIRECT = 2'd0,
    SRC_PTRP   = 2'd1,
    SRC_PTRQ   = 2'd2,
    SRC_STACK  = 2'd3
  } srcSel_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_RSVD = 2'd3
  } ptrOp_e;

  typedef enum logic [2:0] {
    BASE_DIRECT = 3'd0,
    BASE_P      = 3'd1,
    BASE_Q      = 3'd2,
    BASE_SP     = 3'd3,
    BASE_SPNEXT = 3'd4
  } baseSel_e;

  typedef struct packed {
    logic [NUM_MAPPED-1:0] ld;     // load from wrData, indexed by IDX_*
    logic [1:0]            ptrInc; // [0] = P, [1] = Q
    logic [1:0]            ptrDec;
    logic                  spInc;
    logic                  spDec;
  } stepStrobes_t;

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [AW-1:0] MAP_BASE = 8'hF8
) (
  input  logic                 accValid,
  input  logic                 accWrite,
  input  logic [1:0]           accSrc,
  input  logic [1:0]           accOp,
  input  logic [AW-1:0]        baseAddr,
  output baseSel_e             baseSel,
  output stepStrobes_t         strobes,
  output logic [IDX_W-1:0]     hitIdx,
  output logic                 memRd,
  output logic                 memWr,
  output logic                 regHit
);

  srcSel_e src;
  ptrOp_e  op;
  logic    inWindow;

  assign src = srcSel_e'(accSrc);
  assign op  = ptrOp_e'(accOp);

  always_comb begin
    unique case (src)
      SRC_DIRECT: baseSel = BASE_DIRECT;
      SRC_PTRP:   baseSel = BASE_P;
      SRC_PTRQ:   baseSel = BASE_Q;
      default:    baseSel = (op == OP_UP) ? BASE_SPNEXT : BASE_SP;
    endcase
  end

  assign inWindow = (baseAddr[AW-1:IDX_W] == MAP_BASE[AW-1:IDX_W]);
  assign hitIdx   = baseAddr[IDX_W-1:0];

  assign regHit = accValid && inWindow;
  assign memRd  = accValid && !accWrite && !inWindow;
  assign memWr  = accValid &&  accWrite && !inWindow;

  genvar k;
  generate
    for (k = 0; k < NUM_MAPPED; k++) begin : g_ld
      assign strobes.ld[k] = accValid && accWrite && inWindow &&
                             (hitIdx == IDX_W'(k));
    end
  endgenerate

  // Adjustments yield to a load of the same register.
  logic [1:0] ptrPick;
  assign ptrPick[0] = accValid && (src == SRC_PTRP) && !strobes.ld[IDX_P];
  assign ptrPick[1] = accValid && (src == SRC_PTRQ) && !strobes.ld[IDX_Q];

  assign strobes.ptrInc = ptrPick & {2{op == OP_UP}};
  assign strobes.ptrDec = ptrPick & {2{op == OP_DOWN}};

  logic stackPick;
  assign stackPick   = accValid && (src == SRC_STACK) && !strobes.ld[IDX_SP];
  assign strobes.spInc = stackPick && (op == OP_UP);
  assign strobes.spDec = stackPick && (op == OP_DOWN);

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            SEGW     = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h6F
) (
  input  logic               clk,
  input  logic               rstN,
  input  baseSel_e           baseSel,
  input  stepStrobes_t       strobes,
  input  logic [IDX_W-1:0]   hitIdx,
  input  logic [AW-1:0]      accDirAddr,
  input  logic [AW-1:0]      wrData,
  output logic [AW-1:0]      baseAddr,
  output logic [SEGW+AW-1:0] extAddr,
  output logic [AW-1:0]      rdData,
  output logic [AW-1:0]      regP,
  output logic [AW-1:0]      regQ,
  output logic [AW-1:0]      regSp,
  output logic [SEGW-1:0]    regBank
);

  localparam int LOW_W = AW - 1;
  localparam int EXT_W = SEGW + AW;

  logic [AW-1:0] ptrQ [2];
  localparam int PTR_IDX [2] = '{IDX_P, IDX_Q};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_ptr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          ptrQ[g] <= '0;
        else if (strobes.ld[PTR_IDX[g]])    ptrQ[g] <= wrData;
        else if (strobes.ptrInc[g])         ptrQ[g] <= ptrQ[g] + AW'(1);
        else if (strobes.ptrDec[g])         ptrQ[g] <= ptrQ[g] - AW'(1);
      end
    end
  endgenerate

  assign regP = ptrQ[0];
  assign regQ = ptrQ[1];

  logic [AW-1:0] spNext;
  assign spNext = regSp + AW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  regSp <= SP_RESET;
    else if (strobes.ld[IDX_SP]) regSp <= wrData;
    else if (strobes.spInc)     regSp <= spNext;
    else if (strobes.spDec)     regSp <= regSp - AW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     regBank <= '0;
    else if (strobes.ld[IDX_BANK]) regBank <= SEGW'(wrData);
  end

  always_comb begin
    unique case (baseSel)
      BASE_P:      baseAddr = regP;
      BASE_Q:      baseAddr = regQ;
      BASE_SP:     baseAddr = regSp;
      BASE_SPNEXT: baseAddr = spNext;
      default:     baseAddr = accDirAddr;
    endcase
  end

  // Lower half is banked, upper half is common to all banks.
  always_comb begin
    if (baseAddr[AW-1]) extAddr = EXT_W'(baseAddr);
    else                extAddr = {regBank, 1'b0, baseAddr[LOW_W-1:0]};
  end

  always_comb begin
    unique case (hitIdx)
      IDX_W'(IDX_P):  rdData = regP;
      IDX_W'(IDX_Q):  rdData = regQ;
      IDX_W'(IDX_SP): rdData = regSp;
      default:        rdData = AW'(regBank);
    endcase
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            SEGW     = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h6F,
  parameter logic [AW-1:0] MAP_BASE = 8'hF8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic [1:0]         accSrc,
  input  logic [1:0]         accOp,
  input  logic [AW-1:0]      accDirAddr,
  input  logic [AW-1:0]      wrData,
  output logic [SEGW+AW-1:0] extAddr,
  output logic               memRd,
  output logic               memWr,
  output logic               regHit,
  output logic [AW-1:0]      rdData
);

  baseSel_e         baseSel;
  stepStrobes_t     strobes;
  logic [IDX_W-1:0] hitIdx;
  logic [AW-1:0]    baseAddr;
  logic [AW-1:0]    regP, regQ, regSp;
  logic [SEGW-1:0]  regBank;

  seg_addr_ctrl #(.AW(AW), .MAP_BASE(MAP_BASE)) i_ctrl (
    .accValid (accValid),
    .accWrite (accWrite),
    .accSrc   (accSrc),
    .accOp    (accOp),
    .baseAddr (baseAddr),
    .baseSel  (baseSel),
    .strobes  (strobes),
    .hitIdx   (hitIdx),
    .memRd    (memRd),
    .memWr    (memWr),
    .regHit   (regHit)
  );

  seg_addr_dp #(.AW(AW), .SEGW(SEGW), .SP_RESET(SP_RESET)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .baseSel    (baseSel),
    .strobes    (strobes),
    .hitIdx     (hitIdx),
    .accDirAddr (accDirAddr),
    .wrData     (wrData),
    .baseAddr   (baseAddr),
    .extAddr    (extAddr),
    .rdData     (rdData),
    .regP       (regP),
    .regQ       (regQ),
    .regSp      (regSp),
    .regBank    (regBank)
  );

endmodule

// File: rtl/seg_addr_checker.sv
module seg_addr_checker #(
  parameter int            AW       = 8,
  parameter int            SEGW     = 8,
  parameter logic [AW-1:0] MAP_BASE = 8'hF8
) (
  input logic               clk,
  input logic               rstN,
  input logic               accValid,
  input logic               accWrite,
  input logic [1:0]         accSrc,
  input logic [1:0]         accOp,
  input logic [AW-1:0]      baseAddr,
  input logic [SEGW+AW-1:0] extAddr,
  input logic               memRd,
  input logic               memWr,
  input logic               regHit,
  input logic [AW-1:0]      regP,
  input logic [AW-1:0]      regQ,
  input logic [AW-1:0]      regSp,
  input logic [SEGW-1:0]    regBank
);

  logic loadsP, loadsSp;
  assign loadsP  = accWrite && (baseAddr == MAP_BASE);
  assign loadsSp = accWrite && (baseAddr == MAP_BASE + AW'(2));

  assert_lower_banked_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !baseAddr[AW-1]) |->
      (extAddr[SEGW+AW-1:AW] == regBank && !extAddr[AW-1]));

  assert_upper_common_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && baseAddr[AW-1]) |-> (extAddr[SEGW+AW-1:AW] == '0));

  assert_p_post_inc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accSrc == 2'd1 && accOp == 2'd1 && !loadsP) |=>
      (regP == $past(regP) + AW'(1)));

  assert_push_dec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accSrc == 2'd3 && accOp == 2'd2 && !loadsSp) |=>
      (regSp == $past(regSp) - AW'(1)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> ($stable(regP) && $stable(regQ) && $stable(regSp) && $stable(regBank)));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({memRd, memWr, regHit}) <= 1);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !(memRd || memWr || regHit));

endmodule

bind seg_addr_gen seg_addr_checker #(.AW(AW), .SEGW(SEGW), .MAP_BASE(MAP_BASE)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .accWrite (accWrite),
  .accSrc   (accSrc),
  .accOp    (accOp),
  .baseAddr (baseAddr),
  .extAddr  (extAddr),
  .memRd    (memRd),
  .memWr    (memWr),
  .regHit   (regHit),
  .regP     (regP),
  .regQ     (regQ),
  .regSp    (regSp),
  .regBank  (regBank)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;

  localparam int MAPB = 'hF8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0;
  logic [1:0]  accSrc = '0, accOp = '0;
  logic [7:0]  accDirAddr = '0, wrData = '0;
  logic [15:0] extAddr;
  logic        memRd, memWr, regHit;
  logic [7:0]  rdData;

  int errors = 0, checks = 0;
  bit done = 0;
  int mReg [4];  // 0 P, 1 Q, 2 SP, 3 bank

  always #2.5 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSrc(accSrc), .accOp(accOp), .accDirAddr(accDirAddr), .wrData(wrData),
    .extAddr(extAddr), .memRd(memRd), .memWr(memWr), .regHit(regHit),
    .rdData(rdData)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit w, int src, int op, int dir, int data);
    int base, idx, eExt;
    bit inWin;
    @(negedge clk);
    accValid = v; accWrite = w; accSrc = 2'(src); accOp = 2'(op);
    accDirAddr = 8'(dir); wrData = 8'(data);
    #1;
    case (src)
      0: base = dir & 255;
      1: base = mReg[0];
      2: base = mReg[1];
      default: base = (op == 1) ? ((mReg[2] + 1) & 255) : mReg[2];
    endcase
    inWin = ((base >> 2) == (MAPB >> 2));
    idx   = base & 3;
    eExt  = (base >= 128) ? base : ((mReg[3] << 8) | (base & 127));
    chk(tag, "memRd",  int'(memRd),  int'(v && !w && !inWin));
    chk(tag, "memWr",  int'(memWr),  int'(v && w && !inWin));
    chk(tag, "regHit", int'(regHit), int'(v && inWin));
    if (v) chk(tag, "extAddr", int'(extAddr), eExt);
    if (v && !w && inWin) chk(tag, "rdData", int'(rdData), mReg[idx]);
    if (v) begin
      bit ld = w && inWin;
      if (src == 1 || src == 2) begin
        if (op == 1) mReg[src-1] = (mReg[src-1] + 1) & 255;
        if (op == 2) mReg[src-1] = (mReg[src-1] + 255) & 255;
      end
      if (src == 3) begin
        if (op == 1) mReg[2] = (mReg[2] + 1) & 255;
        if (op == 2) mReg[2] = (mReg[2] + 255) & 255;
      end
      if (ld) mReg[idx] = data & 255;  // R9: load overrides adjust
    end
  endtask

  task automatic readAll(string tag);
    for (int k = 0; k < 4; k++) step(tag, 1, 0, 0, 0, MAPB + k, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mReg = '{0, 0, 'h6F, 0};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values, R8 mapped reads
    readAll("R1");
    // R7 loads through the mapped window
    step("R7", 1, 1, 0, 0, MAPB + 3, 'h5A);
    step("R7", 1, 1, 0, 0, MAPB + 0, 'h10);
    step("R7", 1, 1, 0, 0, MAPB + 1, 'hFE);
    readAll("R8");
    // R2 lower banked, R3 upper common, R4 direct ignores accOp
    step("R2", 1, 0, 0, 1, 'h23, 0);
    step("R3", 1, 1, 0, 2, 'h90, 0);
    step("R4", 1, 0, 0, 2, 'h7F, 0);
    step("R4", 1, 0, 0, 0, 'h80, 0);
    // R5 pointer post-modify and wrap
    repeat (3) step("R5", 1, 0, 1, 1, 0, 0);
    step("R5", 1, 1, 1, 2, 0, 0);
    step("R5", 1, 0, 1, 3, 0, 0);
    repeat (3) step("R5", 1, 0, 2, 1, 0, 0);  // 0xFE, 0xFF, 0x00
    repeat (2) step("R5", 1, 0, 2, 2, 0, 0);  // 0x00 -> 0xFF
    // R6 stack push and pop
    step("R6", 1, 1, 3, 2, 0, 0);
    step("R6", 1, 1, 3, 2, 0, 0);
    step("R6", 1, 0, 3, 0, 0, 0);
    step("R6", 1, 0, 3, 1, 0, 0);
    step("R6", 1, 0, 3, 1, 0, 0);
    step("R6", 1, 0, 3, 3, 0, 0);
    // R10 idle cycles with busy inputs
    step("R10", 0, 1, 1, 1, MAPB, 'hAA);
    step("R10", 0, 1, 3, 2, MAPB + 2, 'hBB);
    readAll("R10");
    // R9 collision: P points at its own mapped slot and post-increments
    step("R9", 1, 1, 0, 0, MAPB + 0, MAPB);
    step("R9", 1, 1, 1, 1, 0, 'h33);
    step("R9", 1, 1, 0, 0, MAPB + 2, MAPB + 2);
    step("R9", 1, 1, 3, 2, 0, 'h40);
    step("R9", 1, 1, 0, 0, MAPB + 1, MAPB + 1);
    step("R9", 1, 1, 2, 2, 0, 'h05);
    readAll("R9");
    // bank change seen on lower-half accesses only
    step("R7", 1, 1, 0, 0, MAPB + 3, 'hC3);
    step("R2", 1, 0, 1, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 'hC3, 0);
    step("R2", 1, 0, 3, 2, 0, 0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule